// File: doc/BRIEF.md
# Rectangular Page Table Refill Engine

The block is a set of bus-master refill engines. Each engine walks a chain of refill descriptors held in memory. A descriptor names a rectangle of entries in a two-dimensional lookup table, the table bank to update, the address of an array of 32-bit page addresses, and the address of the next descriptor. The engine reads the descriptor, checks it, fetches one data word per covered entry, and writes each word into the table through a dedicated write port. It then follows the chain until it reads a zero next pointer.

Software drives each engine through a small word-addressed register file. Writing a nonzero descriptor address starts a walk. Writing zero aborts a walk or clears the result of the last one. A per-engine status word reports progress. A shared interrupt status register gives each engine its own 8-bit field, and a write-one set/clear enable pair masks those bits onto a single registered interrupt line.

Memory reads use a valid/ready request channel and a response strobe, with at most one read outstanding per engine. The default build has two engines. The interrupt status register holds up to four engines.

Top module: `dte_top`

## Requirements
- R1: After reset every engine status reads 0x1 (READY only), the interrupt status and enable registers read 0, `irq` is low and no memory request is valid.
- R2: A descriptor is five 32-bit words at its address: +0 holds x0 in bits [15:0] and y0 in bits [31:16], +4 holds x1 and y1 in the same positions, +8 is control with bit 0 the start flag and bits [11:8] the table bank, +12 the data array address, and +16 the next descriptor address. Only the low COORD_W bits of each coordinate are used. All memory reads are word aligned.
- R3: A descriptor with the start flag set writes (x1-x0+1)*(y1-y0+1) table entries in row-major order, x stepping fastest. Entry i takes the word at data address + 4*i, and every write carries the descriptor's bank on `tbl_lut`.
- R4: The engine follows next pointers until one reads zero. A descriptor whose start flag is clear writes no entries but still passes on to its next descriptor.
- R5: At chain end the status reads 0x7 (bit 0 READY, bit 1 VALID, bit 2 DONE, bit 3 ERR). The engine's interrupt field sets bit 1 (last descriptor done) and bit 0 (descriptor loaded), and bit 0 is set again for every descriptor that is read.
- R6: A descriptor or next address with bits [3:0] not all zero sets field bit 2. A data address with bits [3:0] not all zero sets bit 3. A rectangle with x1<x0 or y1<y0 sets bit 4. Each of these errors stops the walk with no table write for that descriptor and leaves the status at 0x9.
- R7: Writing zero to an engine's pointer register stops the walk at once: no further table write is made and no further request is issued. The status reads 0x1 once no read is outstanding, and no completion or error bit is raised.
- R8: Writing a nonzero pointer while the engine is not READY has no effect.
- R9: The interrupt status register (word 0) holds engine n's field in bits [8n+7:8n]. Writing ones clears those bits, and a new event in the same cycle wins over the clear.
- R10: Writing ones to word 1 sets enable bits and writing ones to word 2 clears them; both words read back the enables. `irq` is the OR of status AND enable, registered, so it follows one cycle after the status or enable change.
- R11: Each engine keeps at most one read outstanding and holds a request's address stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address (0 irq status, 1 enable set, 2 enable clear, 8+2n engine n pointer, 9+2n engine n status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the address |
| irq | output | 1 | Registered interrupt line |
| mem_req_valid | output | NUM_ENG | Read request valid, one bit per engine |
| mem_req_addr | output | 32*NUM_ENG | Read byte address, engine n in bits [32n+31:32n] |
| mem_req_ready | input | NUM_ENG | Read request accepted |
| mem_rsp_valid | input | NUM_ENG | Read data strobe |
| mem_rsp_data | input | 32*NUM_ENG | Read data per engine |
| tbl_we | output | NUM_ENG | Table entry write strobe |
| tbl_x | output | COORD_W*NUM_ENG | Entry column |
| tbl_y | output | COORD_W*NUM_ENG | Entry row |
| tbl_lut | output | LUT_W*NUM_ENG | Target table bank |
| tbl_data | output | 32*NUM_ENG | Page address written to the entry |

## Verification
A wrong walk state shows up directly on the table write port. A wrong rectangle step, a misread descriptor word or a stale data address gives a write with the wrong coordinate or data on the very next entry, so every write is compared in order against a queue built from the descriptors. A broken abort or a failed busy-ignore shows up as a write the queue does not hold. Status and interrupt errors appear in the next register read once the engine goes idle, and a wrong enable or a broken clear path shows on `irq` one cycle after the write.

// File: rtl/dte_pkg.sv
package dte_pkg;
  // engine status bit positions
  localparam int ST_READY = 0;
  localparam int ST_VALID = 1;
  localparam int ST_DONE  = 2;
  localparam int ST_ERR   = 3;

  // per-engine interrupt field bit positions
  localparam int EV_DESC    = 0;  // descriptor loaded (advisory)
  localparam int EV_LAST    = 1;  // chain finished
  localparam int EV_BADPTR  = 2;  // descriptor or next address misaligned
  localparam int EV_BADDATA = 3;  // data array address misaligned
  localparam int EV_BADRECT = 4;  // inverted rectangle

  localparam int DESC_WORDS = 5;

  typedef enum logic [2:0] {
    E_IDLE, E_DREQ, E_DRSP, E_CHECK, E_WREQ, E_WRSP, E_NEXT
  } eng_state_t;
endpackage

// File: rtl/dte_irq.sv
module dte_irq #(
  parameter int IRQ_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IRQ_W-1:0] ev,
  input  logic             stat_we,
  input  logic             en_set_we,
  input  logic             en_clr_we,
  input  logic [IRQ_W-1:0] wdata,
  output logic [IRQ_W-1:0] stat,
  output logic [IRQ_W-1:0] en,
  output logic             irq
);
  logic [IRQ_W-1:0] clr_mask;

  assign clr_mask = stat_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      en   <= '0;
      irq  <= 1'b0;
    end else begin
      stat <= (stat & ~clr_mask) | ev;
      if (en_set_we) en <= en | wdata;
      else if (en_clr_we) en <= en & ~wdata;
      irq <= |(stat & en);
    end
  end

  // R10: the line only rises on a masked status seen the cycle before
  p_irq_reg_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(stat & en)));
  // R9: cleared bits are gone unless an event re-raised them
  p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
    stat_we |=> ((stat & $past(wdata & ~ev)) == '0));
  // R9: an event always lands, even against a clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (|ev) |=> ((stat & $past(ev)) == $past(ev)));
  // R10: set writes reach the enable register
  p_en_set_r10: assert property (@(posedge clk) disable iff (rst)
    en_set_we |=> ((en & $past(wdata)) == $past(wdata)));
endmodule

// File: rtl/dte_engine.sv
module dte_engine
  import dte_pkg::*;
#(
  parameter int COORD_W = 8,
  parameter int LUT_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ptr_we,
  input  logic [31:0]        ptr_wdata,
  output logic [31:0]        ptr_rd,
  output logic [3:0]         status,
  output logic [7:0]         ev,
  output logic               mem_req_valid,
  output logic [31:0]        mem_req_addr,
  input  logic               mem_req_ready,
  input  logic               mem_rsp_valid,
  input  logic [31:0]        mem_rsp_data,
  output logic               tbl_we,
  output logic [COORD_W-1:0] tbl_x,
  output logic [COORD_W-1:0] tbl_y,
  output logic [LUT_W-1:0]   tbl_lut,
  output logic [31:0]        tbl_data
);
  localparam int WIDX_W = $clog2(DESC_WORDS);

  eng_state_t         state_q;
  logic [WIDX_W-1:0]  widx_q;
  logic [31:0]        addr_q, dptr_q, next_q, ptr_q;
  logic [COORD_W-1:0] x0_q, y0_q, x1_q, y1_q, cx_q, cy_q;
  logic               start_q, req_q, pend_q;
  logic [LUT_W-1:0]   lut_q;
  logic               valid_q, done_q, err_q;
  logic               abort;

  assign abort         = ptr_we && (ptr_wdata == '0);
  assign mem_req_valid = req_q;
  assign mem_req_addr  = addr_q;
  assign ptr_rd        = ptr_q;
  assign status        = {err_q, done_q, valid_q, (state_q == E_IDLE) && !pend_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= E_IDLE;
      widx_q   <= '0;
      addr_q   <= '0;
      dptr_q   <= '0;
      next_q   <= '0;
      ptr_q    <= '0;
      x0_q     <= '0;
      y0_q     <= '0;
      x1_q     <= '0;
      y1_q     <= '0;
      cx_q     <= '0;
      cy_q     <= '0;
      start_q  <= 1'b0;
      lut_q    <= '0;
      req_q    <= 1'b0;
      pend_q   <= 1'b0;
      valid_q  <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      ev       <= '0;
      tbl_we   <= 1'b0;
      tbl_x    <= '0;
      tbl_y    <= '0;
      tbl_lut  <= '0;
      tbl_data <= '0;
    end else begin
      tbl_we <= 1'b0;
      ev     <= '0;
      pend_q <= (pend_q && !mem_rsp_valid) || (req_q && mem_req_ready);
      if (abort) begin
        state_q <= E_IDLE;
        req_q   <= 1'b0;
        ptr_q   <= '0;
        valid_q <= 1'b0;
        done_q  <= 1'b0;
        err_q   <= 1'b0;
      end else begin
        unique case (state_q)
          E_IDLE: begin
            if (ptr_we && !pend_q) begin
              ptr_q   <= ptr_wdata;
              valid_q <= 1'b0;
              done_q  <= 1'b0;
              if (ptr_wdata[3:0] != 4'd0) begin
                err_q         <= 1'b1;
                ev[EV_BADPTR] <= 1'b1;
              end else begin
                err_q   <= 1'b0;
                addr_q  <= ptr_wdata;
                widx_q  <= '0;
                req_q   <= 1'b1;
                state_q <= E_DREQ;
              end
            end
          end
          E_DREQ, E_WREQ: begin
            if (mem_req_ready) begin
              req_q   <= 1'b0;
              state_q <= (state_q == E_DREQ) ? E_DRSP : E_WRSP;
            end
          end
          E_DRSP: begin
            if (mem_rsp_valid) begin
              case (widx_q)
                WIDX_W'(0): begin
                  x0_q <= mem_rsp_data[COORD_W-1:0];
                  y0_q <= mem_rsp_data[16 +: COORD_W];
                end
                WIDX_W'(1): begin
                  x1_q <= mem_rsp_data[COORD_W-1:0];
                  y1_q <= mem_rsp_data[16 +: COORD_W];
                end
                WIDX_W'(2): begin
                  start_q <= mem_rsp_data[0];
                  lut_q   <= mem_rsp_data[8 +: LUT_W];
                end
                WIDX_W'(3): dptr_q <= mem_rsp_data;
                default:    next_q <= mem_rsp_data;
              endcase
              if (widx_q == WIDX_W'(DESC_WORDS - 1)) begin
                state_q <= E_CHECK;
              end else begin
                widx_q  <= widx_q + 1'b1;
                addr_q  <= addr_q + 32'd4;
                req_q   <= 1'b1;
                state_q <= E_DREQ;
              end
            end
          end
          E_CHECK: begin
            ev[EV_DESC] <= 1'b1;
            if (!start_q) begin
              state_q <= E_NEXT;
            end else if (dptr_q[3:0] != 4'd0) begin
              err_q          <= 1'b1;
              ev[EV_BADDATA] <= 1'b1;
              state_q        <= E_IDLE;
            end else if ((x1_q < x0_q) || (y1_q < y0_q)) begin
              err_q          <= 1'b1;
              ev[EV_BADRECT] <= 1'b1;
              state_q        <= E_IDLE;
            end else begin
              cx_q    <= x0_q;
              cy_q    <= y0_q;
              addr_q  <= dptr_q;
              req_q   <= 1'b1;
              state_q <= E_WREQ;
            end
          end
          E_WRSP: begin
            if (mem_rsp_valid) begin
              tbl_we   <= 1'b1;
              tbl_x    <= cx_q;
              tbl_y    <= cy_q;
              tbl_lut  <= lut_q;
              tbl_data <= mem_rsp_data;
              addr_q   <= addr_q + 32'd4;
              if ((cx_q == x1_q) && (cy_q == y1_q)) begin
                state_q <= E_NEXT;
              end else begin
                if (cx_q == x1_q) begin
                  cx_q <= x0_q;
                  cy_q <= cy_q + 1'b1;
                end else begin
                  cx_q <= cx_q + 1'b1;
                end
                req_q   <= 1'b1;
                state_q <= E_WREQ;
              end
            end
          end
          E_NEXT: begin
            if (next_q == '0) begin
              valid_q     <= 1'b1;
              done_q      <= 1'b1;
              ev[EV_LAST] <= 1'b1;
              state_q     <= E_IDLE;
            end else if (next_q[3:0] != 4'd0) begin
              err_q         <= 1'b1;
              ev[EV_BADPTR] <= 1'b1;
              state_q       <= E_IDLE;
            end else begin
              addr_q  <= next_q;
              widx_q  <= '0;
              req_q   <= 1'b1;
              state_q <= E_DREQ;
            end
          end
          default: state_q <= E_IDLE;
        endcase
      end
    end
  end

  // R11: a stalled request keeps its address until accepted
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready && !abort) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R11: no new request while a read is outstanding
  p_single_out_r11: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> !mem_req_valid);
  // R2: reads are always word aligned
  p_aligned_req_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));
  // R3: every table write is fed by a returned data word
  p_write_after_rsp_r3: assert property (@(posedge clk) disable iff (rst)
    tbl_we |-> $past(mem_rsp_valid));
  // R7: an abort silences both ports on the next cycle
  p_abort_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!tbl_we && !mem_req_valid));
  // R6: an error result never reports completion
  p_err_done_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(status[ST_ERR] && status[ST_DONE]));
endmodule

// File: rtl/dte_top.sv
module dte_top #(
  parameter int NUM_ENG = 2,
  parameter int COORD_W = 8,
  parameter int LUT_W   = 4,
  parameter int ADDR_W  = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_we,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  output logic                       irq,
  output logic [NUM_ENG-1:0]         mem_req_valid,
  output logic [32*NUM_ENG-1:0]      mem_req_addr,
  input  logic [NUM_ENG-1:0]         mem_req_ready,
  input  logic [NUM_ENG-1:0]         mem_rsp_valid,
  input  logic [32*NUM_ENG-1:0]      mem_rsp_data,
  output logic [NUM_ENG-1:0]         tbl_we,
  output logic [COORD_W*NUM_ENG-1:0] tbl_x,
  output logic [COORD_W*NUM_ENG-1:0] tbl_y,
  output logic [LUT_W*NUM_ENG-1:0]   tbl_lut,
  output logic [32*NUM_ENG-1:0]      tbl_data
);
  localparam int IRQ_W    = 8 * NUM_ENG;
  localparam int A_STAT   = 0;
  localparam int A_ENSET  = 1;
  localparam int A_ENCLR  = 2;
  localparam int ENG_BASE = 8;

  logic [IRQ_W-1:0] ev_all, irq_stat, irq_en;
  logic [31:0]      ptr_v  [NUM_ENG];
  logic [3:0]       stat_v [NUM_ENG];
  logic [31:0]      rd_mux;

  for (genvar n = 0; n < NUM_ENG; n++) begin : g_eng
    logic ptr_we_n;
    assign ptr_we_n = reg_we && (reg_addr == ADDR_W'(ENG_BASE + 2 * n));
    dte_engine #(.COORD_W(COORD_W), .LUT_W(LUT_W)) u_eng (
      .clk          (clk),
      .rst          (rst),
      .ptr_we       (ptr_we_n),
      .ptr_wdata    (reg_wdata),
      .ptr_rd       (ptr_v[n]),
      .status       (stat_v[n]),
      .ev           (ev_all[8*n +: 8]),
      .mem_req_valid(mem_req_valid[n]),
      .mem_req_addr (mem_req_addr[32*n +: 32]),
      .mem_req_ready(mem_req_ready[n]),
      .mem_rsp_valid(mem_rsp_valid[n]),
      .mem_rsp_data (mem_rsp_data[32*n +: 32]),
      .tbl_we       (tbl_we[n]),
      .tbl_x        (tbl_x[COORD_W*n +: COORD_W]),
      .tbl_y        (tbl_y[COORD_W*n +: COORD_W]),
      .tbl_lut      (tbl_lut[LUT_W*n +: LUT_W]),
      .tbl_data     (tbl_data[32*n +: 32])
    );
  end

  dte_irq #(.IRQ_W(IRQ_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev_all),
    .stat_we  (reg_we && (reg_addr == ADDR_W'(A_STAT))),
    .en_set_we(reg_we && (reg_addr == ADDR_W'(A_ENSET))),
    .en_clr_we(reg_we && (reg_addr == ADDR_W'(A_ENCLR))),
    .wdata    (reg_wdata[IRQ_W-1:0]),
    .stat     (irq_stat),
    .en       (irq_en),
    .irq      (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(A_STAT)) rd_mux = 32'(irq_stat);
    if ((reg_addr == ADDR_W'(A_ENSET)) || (reg_addr == ADDR_W'(A_ENCLR))) rd_mux = 32'(irq_en);
    for (int n = 0; n < NUM_ENG; n++) begin
      if (reg_addr == ADDR_W'(ENG_BASE + 2 * n))     rd_mux = ptr_v[n];
      if (reg_addr == ADDR_W'(ENG_BASE + 2 * n + 1)) rd_mux = 32'(stat_v[n]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  // R1: no engine requests memory in the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $fell(rst) |-> (mem_req_valid == '0));
endmodule

// File: tb/tb_dte_top.sv
module tb_dte_top;
  localparam int NE = 2, CW = 8, LW = 4, AW = 5;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic               reg_we = 1'b0;
  logic [AW-1:0]      reg_addr = '0;
  logic [31:0]        reg_wdata = '0, reg_rdata;
  logic               irq;
  logic [NE-1:0]      mem_req_valid, mem_req_ready = '0, mem_rsp_valid = '0;
  logic [32*NE-1:0]   mem_req_addr, mem_rsp_data = '0;
  logic [NE-1:0]      tbl_we;
  logic [CW*NE-1:0]   tbl_x, tbl_y;
  logic [LW*NE-1:0]   tbl_lut;
  logic [32*NE-1:0]   tbl_data;

  dte_top #(.NUM_ENG(NE), .COORD_W(CW), .LUT_W(LW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .tbl_we(tbl_we), .tbl_x(tbl_x), .tbl_y(tbl_y), .tbl_lut(tbl_lut), .tbl_data(tbl_data));

  logic [31:0] mem [0:4095];
  logic [63:0] expq [NE][$];
  int n_chk = 0, n_bad = 0, n_unexp = 0, n_viol = 0, cyc = 0;
  bit          out_f [NE];
  int          cnt   [NE];
  logic [31:0] la    [NE];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model and table-write monitor
  always @(negedge clk) begin
    for (int e = 0; e < NE; e++) begin
      mem_rsp_valid[e] = 1'b0;
      if (rst) begin
        mem_req_ready[e] = 1'b0;
        out_f[e] = 1'b0;
      end else if (out_f[e]) begin
        mem_req_ready[e] = 1'b0;
        if (mem_req_valid[e]) n_viol++;  // R11: request while outstanding
        if (cnt[e] == 0) begin
          mem_rsp_valid[e] = 1'b1;
          mem_rsp_data[32*e +: 32] = mem[la[e][13:2]];
          out_f[e] = 1'b0;
        end else cnt[e]--;
      end else if (mem_req_valid[e] && ($urandom % 4 != 0)) begin
        mem_req_ready[e] = 1'b1;
        out_f[e] = 1'b1;
        la[e] = mem_req_addr[32*e +: 32];
        cnt[e] = $urandom % 3;
      end else mem_req_ready[e] = 1'b0;
      if (!rst && tbl_we[e]) begin
        logic [63:0] got;
        got = {12'h0, tbl_lut[LW*e +: LW], tbl_y[CW*e +: CW], tbl_x[CW*e +: CW], tbl_data[32*e +: 32]};
        if (expq[e].size() == 0) begin
          n_unexp++; n_bad++;
          $display("FAIL R3 unexpected table write e%0d: actual %h expected none", e, got);
        end else begin
          logic [63:0] want;
          want = expq[e].pop_front();
          n_chk++;
          if (got !== want) begin
            n_bad++;
            $display("FAIL R3 table write e%0d: actual %h expected %h", e, got, want);
          end
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); reg_addr = AW'(a);
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic poll(int e, output logic [31:0] s);
    for (int i = 0; i < 3000; i++) begin
      rd(9 + 2 * e, s);
      if (s[0]) break;
    end
  endtask

  // R2: descriptor words; R3: expected row-major entries
  task automatic put_desc(int e, logic [31:0] dp, int x0, int y0, int x1, int y1, bit st,
                          int lut, logic [31:0] dd, logic [31:0] nx, bit expect_w);
    int i;
    mem[dp[13:2]]     = {16'(y0), 16'(x0)};
    mem[dp[13:2] + 1] = {16'(y1), 16'(x1)};
    mem[dp[13:2] + 2] = {20'h0, 4'(lut), 7'h0, st};
    mem[dp[13:2] + 3] = dd;
    mem[dp[13:2] + 4] = nx;
    i = 0;
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++) begin
        logic [31:0] d;
        d = $urandom;
        mem[dd[13:2] + i] = d;
        if (st && expect_w) expq[e].push_back({12'h0, 4'(lut), 8'(y), 8'(x), d});
        i++;
      end
  endtask

  logic [31:0] v;

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 mem_req_valid", 32'(mem_req_valid), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(9, v);  chk("R1 status e0", v, 32'h1);
    rd(11, v); chk("R1 status e1", v, 32'h1);
    rd(0, v);  chk("R1 irq status", v, 0);
    rd(1, v);  chk("R1 enables", v, 0);

    // R2 R3 R5 single descriptor, enables still off
    put_desc(0, 32'h100, 2, 3, 4, 4, 1'b1, 5, 32'h400, 32'h0, 1'b1);
    wr(8, 32'h100);
    poll(0, v);
    chk("R5 status done", v, 32'h7);
    chk("R3 queue drained", 32'(expq[0].size()), 0);
    rd(0, v); chk("R5 R9 field e0", v, 32'h0003);
    chk("R10 irq masked", 32'(irq), 0);
    wr(1, 32'h7E7E); @(negedge clk);
    chk("R10 irq enabled", 32'(irq), 1);
    rd(1, v); chk("R10 enable readback", v, 32'h7E7E);
    wr(2, 32'h0202); @(negedge clk);
    chk("R10 irq after clear-enable", 32'(irq), 0);
    rd(2, v); chk("R10 enable after clear", v, 32'h7C7C);
    wr(1, 32'h0202);
    wr(0, 32'h0001); rd(0, v); chk("R9 partial clear", v, 32'h0002);
    wr(0, 32'h0002); @(negedge clk);
    chk("R9 irq after clear", 32'(irq), 0);
    rd(0, v); chk("R9 all cleared", v, 0);

    // R8 second pointer while busy is ignored
    put_desc(0, 32'h100, 0, 0, 7, 7, 1'b1, 2, 32'h400, 32'h0, 1'b1);
    put_desc(0, 32'h140, 9, 9, 10, 10, 1'b1, 6, 32'h800, 32'h0, 1'b0);
    wr(8, 32'h100);
    wr(8, 32'h140);
    poll(0, v);
    chk("R8 status done", v, 32'h7);
    chk("R8 queue drained", 32'(expq[0].size()), 0);
    rd(8, v); chk("R8 pointer kept", v, 32'h100);
    wr(0, 32'hFFFF);

    // R7 abort in the middle of a walk
    put_desc(1, 32'h2100, 0, 0, 7, 7, 1'b1, 3, 32'h2400, 32'h0, 1'b1);
    wr(10, 32'h2100);
    repeat (40) @(negedge clk);
    wr(10, 32'h0);
    #1 expq[1].delete();
    poll(1, v);
    chk("R7 status after abort", v, 32'h1);
    repeat (30) @(negedge clk);
    chk("R7 no writes after abort", 32'(n_unexp), 0);
    rd(0, v); chk("R7 field e1", v, 32'h0100);
    wr(0, 32'hFFFF);

    // R6 error cases
    wr(8, 32'h108); poll(0, v);
    chk("R6 bad pointer status", v, 32'h9);
    rd(0, v); chk("R6 bad pointer field", v, 32'h0004);
    wr(0, 32'hFFFF);
    put_desc(0, 32'h100, 5, 0, 3, 1, 1'b1, 1, 32'h400, 32'h0, 1'b0);
    wr(8, 32'h100); poll(0, v);
    chk("R6 x inverted status", v, 32'h9);
    rd(0, v); chk("R6 x inverted field", v, 32'h0011);
    wr(0, 32'hFFFF);
    put_desc(1, 32'h2100, 0, 4, 1, 2, 1'b1, 1, 32'h2400, 32'h0, 1'b0);
    wr(10, 32'h2100); poll(1, v);
    chk("R6 y inverted status", v, 32'h9);
    rd(0, v); chk("R6 y inverted field", v, 32'h1100);
    wr(0, 32'hFFFF);
    put_desc(0, 32'h100, 0, 0, 1, 1, 1'b1, 1, 32'h404, 32'h0, 1'b0);
    wr(8, 32'h100); poll(0, v);
    chk("R6 bad data status", v, 32'h9);
    rd(0, v); chk("R6 bad data field", v, 32'h0009);
    wr(0, 32'hFFFF);
    put_desc(0, 32'h100, 3, 3, 3, 4, 1'b1, 7, 32'h400, 32'h148, 1'b1);
    wr(8, 32'h100); poll(0, v);
    chk("R6 bad next status", v, 32'h9);
    chk("R6 bad next writes done", 32'(expq[0].size()), 0);
    rd(0, v); chk("R6 bad next field", v, 32'h0005);
    wr(0, 32'hFFFF);
    wr(8, 32'h0); rd(9, v); chk("R7 zero write clears", v, 32'h1);

    // R3 R4 random chains on both engines in parallel
    for (int it = 0; it < 6; it++) begin
      for (int e = 0; e < NE; e++) begin
        int len;
        len = 1 + $urandom % 3;
        for (int k = 0; k < len; k++) begin
          int x0, y0;
          logic [31:0] dp, nx;
          x0 = $urandom % 200; y0 = $urandom % 200;
          dp = 32'(e * 32'h2000 + 32'h100 + k * 32'h40);
          nx = (k == len - 1) ? 32'h0 : dp + 32'h40;
          put_desc(e, dp, x0, y0, x0 + int'($urandom % 4), y0 + int'($urandom % 4),
                   ($urandom % 4) != 0, $urandom % 16,
                   32'(e * 32'h2000 + 32'h400 + k * 32'h100), nx, 1'b1);
        end
      end
      wr(8, 32'h100);
      wr(10, 32'h2100);
      poll(0, v); chk("R4 chain e0 status", v, 32'h7);
      poll(1, v); chk("R4 chain e1 status", v, 32'h7);
      chk("R4 e0 queue drained", 32'(expq[0].size()), 0);
      chk("R4 e1 queue drained", 32'(expq[1].size()), 0);
      rd(0, v); chk("R5 R9 both fields", v, 32'h0303);
      wr(0, 32'hFFFF);
    end

    chk("R11 one outstanding read", 32'(n_viol), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule